// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. The line rests high. A frame is a low start bit, then the character bits with the least significant bit first, then an optional parity bit, then high stop bits. A line-control byte sets the framing: character length (5 to 8 bits), parity on or off, odd, even or fixed parity, and the number of stop bits (one, one and a half, or two).

Bit timing comes from a one-cycle enable pulse that arrives at sixteen times the bit rate. A baud generator outside the block produces it. Characters enter through a valid/ready handshake. The control byte is captured together with the character, so software may reprogram it while a frame is on the line. A break input holds the output at the spacing level (low). The serializer keeps running underneath, so the frame timing and the busy flag are the same as without break.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is low, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: `in_ready` is high only while no frame is in progress. A character is taken on a cycle where `in_valid` and `in_ready` are both high. `in_valid` is ignored while a frame is in progress and produces no extra frame.
- R3: A frame starts with one 0 bit, followed by the character bits with the least significant bit first. The count of character bits is set by `line_ctrl[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: With `line_ctrl[3]` = 0, no parity bit is sent, and the stop bits follow the last character bit directly.
- R5: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 0, a parity bit follows the character bits. With `line_ctrl[4]` = 1 it gives even parity over the sent character bits; with `line_ctrl[4]` = 0 it gives odd parity.
- R6: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 1, the parity bit is a fixed level: 0 when `line_ctrl[4]` = 1, and 1 when `line_ctrl[4]` = 0.
- R7: The stop period is high. It lasts 16 ticks when `line_ctrl[2]` = 0. When `line_ctrl[2]` = 1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6, 7 and 8-bit characters.
- R8: Every start, character and parity bit lasts exactly 16 `tick16` pulses. `busy` stays high for exactly the number of tick pulses the whole frame needs, and the line state moves only on a tick.
- R9: While `brk` is 1, `txd` is 0. Break does not change the frame timing or `busy`. After `brk` returns to 0, `txd` again shows the transmitter's own level.
- R10: `line_ctrl` and `in_data` are sampled only on the accepting cycle. Changing them during a frame has no effect on that frame.
- R11: Character bits above the selected length are neither sent nor counted in the parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| tick16 | input | 1 | One-cycle enable pulse at sixteen times the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter idle and able to take a character |
| in_data | input | DATA_W | Character, least significant bit sent first |
| line_ctrl | input | 8 | Framing control: [1:0] length, [2] stop select, [3] parity on, [4] even select, [5] fixed parity, [7:6] unused |
| brk | input | 1 | Force the line to the spacing level |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions assume that `tick16` is a pulse of at most one cycle and that `in_valid` is honoured only together with `in_ready`. They also assume that a parity state is reached only when the captured control asked for parity. The stimulus produces ticks one cycle in three and raises `in_valid` only after it has seen `in_ready` high. It changes `line_ctrl`, `in_data` and `in_valid` during frames only on purpose, to show that they are ignored there. A scoreboard predicts each frame's bit levels and its total tick count from the control byte. It compares them against `txd`, sampled in the middle of every bit, and against how long `busy` stays high.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [3:0] data_len;
    logic       par_en;
    logic       par_even;
    logic       par_force;
    stop_mode_e stop_mode;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_ctrl_decode.sv
module uart_tx_ctrl_decode
  import uart_tx_pkg::*;
#(
  parameter int MIN_LEN = 5
) (
  input  logic [CTRL_W-1:0] ctrl,
  output frame_cfg_t        cfg
);

  logic short_char;

  always_comb begin
    // the length code counts up from the shortest character
    cfg.data_len  = 4'(MIN_LEN) + {2'b00, ctrl[1:0]};
    cfg.par_en    = ctrl[3];
    cfg.par_even  = ctrl[4];
    cfg.par_force = ctrl[5];
    short_char    = (ctrl[1:0] == 2'b00);
    if (!ctrl[2]) begin
      cfg.stop_mode = STOP_ONE;
    end else if (short_char) begin
      cfg.stop_mode = STOP_ONE_HALF;
    end else begin
      cfg.stop_mode = STOP_TWO;
    end
  end

endmodule

// File: rtl/uart_tx_parity_gen.sv
module uart_tx_parity_gen
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  frame_cfg_t        cfg,
  output logic              par_bit
);

  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  // keep only the bits that go onto the line
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign masked[gi] = data[gi] & (gi < int'(cfg.data_len));
  end

  assign ones_odd = ^masked;

  always_comb begin
    if (cfg.par_force) begin
      par_bit = ~cfg.par_even;
    end else if (cfg.par_even) begin
      par_bit = ones_odd;
    end else begin
      par_bit = ~ones_odd;
    end
  end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  parameter int LIM_W         = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             bit_done
);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_d;
  logic             at_last;

  assign at_last  = (cnt_q == limit - LIM_W'(1));
  assign bit_done = run & tick & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_last ? '0 : cnt_q + LIM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R8
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int LIM_W         = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  frame_cfg_t        in_cfg,
  input  logic              in_par,
  input  logic              bit_done,
  output logic              busy,
  output logic              line,
  output logic [LIM_W-1:0]  bit_limit
);

  localparam int LEFT_W = $clog2(DATA_W + 1);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              par_q, par_d;
  logic              line_q, line_d;
  frame_cfg_t        cfg_q, cfg_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    left_d  = left_q;
    par_d   = par_q;
    line_d  = line_q;
    cfg_d   = cfg_q;
    unique case (state_q)
      ST_IDLE: begin
        line_d = 1'b1;
        if (accept) begin
          state_d = ST_START;
          line_d  = 1'b0;
          shreg_d = in_data;
          cfg_d   = in_cfg;
          par_d   = in_par;
          left_d  = LEFT_W'(in_cfg.data_len);
        end
      end
      ST_START: begin
        if (bit_done) begin
          state_d = ST_DATA;
          line_d  = shreg_q[0];
          shreg_d = shreg_q >> 1;
          left_d  = left_q - LEFT_W'(1);
        end
      end
      ST_DATA: begin
        if (bit_done) begin
          if (left_q != '0) begin
            line_d  = shreg_q[0];
            shreg_d = shreg_q >> 1;
            left_d  = left_q - LEFT_W'(1);
          end else if (cfg_q.par_en) begin
            state_d = ST_PARITY;
            line_d  = par_q;
          end else begin
            state_d = ST_STOP;
            line_d  = 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (bit_done) begin
          state_d = ST_STOP;
          line_d  = 1'b1;
        end
      end
      ST_STOP: begin
        if (bit_done) begin
          state_d = ST_IDLE;
          line_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        line_d  = 1'b1;
      end
    endcase
  end

  always_comb begin
    bit_limit = LIM_W'(TICKS_PER_BIT);
    if (state_q == ST_STOP) begin
      unique case (cfg_q.stop_mode)
        STOP_ONE_HALF: bit_limit = LIM_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
        STOP_TWO:      bit_limit = LIM_W'(2 * TICKS_PER_BIT);
        default:       bit_limit = LIM_W'(TICKS_PER_BIT);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      par_q   <= 1'b0;
      line_q  <= 1'b1;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      left_q  <= left_d;
      par_q   <= par_d;
      line_q  <= line_d;
      cfg_q   <= cfg_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign line = line_q;

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> line_q);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((state_q == ST_START) && !line_q));

  // R4
  parity_only_if_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARITY) |-> cfg_q.par_en);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ((state_q == ST_IDLE) || $stable(cfg_q)));

  // R7
  stop_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> line_q);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] line_ctrl,
  input  logic              brk,
  output logic              txd,
  output logic              busy
);

  localparam int LIM_W = $clog2(2 * TICKS_PER_BIT + 1);

  logic             rst_meta_q;
  logic             rst_sync_q;
  logic             accept;
  logic             ser_busy;
  logic             ser_line;
  logic             par_bit;
  logic             bit_done;
  logic [LIM_W-1:0] bit_limit;
  frame_cfg_t       dec_cfg;

  // assertion is immediate, release waits for two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign in_ready = ~ser_busy;
  assign accept   = in_valid & in_ready;

  uart_tx_ctrl_decode u_decode (
    .ctrl (line_ctrl),
    .cfg  (dec_cfg)
  );

  uart_tx_parity_gen #(.DATA_W(DATA_W)) u_parity (
    .data    (in_data),
    .cfg     (dec_cfg),
    .par_bit (par_bit)
  );

  uart_tx_serializer #(
    .DATA_W        (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .LIM_W         (LIM_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .accept    (accept),
    .in_data   (in_data),
    .in_cfg    (dec_cfg),
    .in_par    (par_bit),
    .bit_done  (bit_done),
    .busy      (ser_busy),
    .line      (ser_line),
    .bit_limit (bit_limit)
  );

  uart_tx_bit_timer #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .LIM_W         (LIM_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run      (ser_busy),
    .tick     (tick16),
    .limit    (bit_limit),
    .bit_done (bit_done)
  );

  assign busy = ser_busy;
  assign txd  = brk ? 1'b0 : ser_line;

  // R2
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_ready) |=> (busy && !in_ready));

  // R9
  break_spacing_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    brk |-> !txd);

  // R8
  idle_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (busy && !tick16) |=> busy);

endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

  typedef struct {
    logic [15:0] bits;
    int          nsamp;
    int          total;
    string       tag;
  } exp_item_t;

  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic [7:0] line_ctrl;
  logic       brk;
  logic       txd;
  logic       busy;

  int n_checks;
  int n_bad;
  bit finished;

  exp_item_t exp_q[$];

  uart_frame_tx uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .line_ctrl (line_ctrl),
    .brk       (brk),
    .txd       (txd),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one tick every third cycle
  initial begin
    tick16 = 1'b0;
    forever begin
      repeat (2) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  // monitor: samples the middle of every bit while busy
  bit          mon_act = 1'b0;
  int          mon_k = 0;
  logic [15:0] mon_got = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!mon_act) begin
          mon_act = 1'b1;
          mon_k   = 0;
          mon_got = '0;
        end
        if (tick16) begin
          if ((mon_k % 16) == 8 && (mon_k / 16) < 16) mon_got[mon_k / 16] = txd;
          mon_k++;
        end
      end else if (mon_act) begin
        mon_act = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", 32'(mon_k), 32'd0);
        end else begin
          exp_item_t e;
          logic [15:0] m;
          e = exp_q.pop_front();
          m = 16'((32'd1 << e.nsamp) - 1);
          chk((mon_got & m) == (e.bits & m), {e.tag, " bits"},
              32'(mon_got & m), 32'(e.bits & m));
          chk(mon_k == e.total, {"R8 ", e.tag, " ticks"}, 32'(mon_k), 32'(e.total));
        end
      end
    end
  end

  // driver: predicts the frame, queues it, then hands the character over
  task automatic send(input logic [7:0] d, input logic [7:0] c, input bit use_brk,
                      input bit scramble, input bit poke_valid, input string tag);
    exp_item_t e;
    int len, n, st;
    logic ones;
    len  = 5 + int'(c[1:0]);
    e.bits = '0;
    ones = 1'b0;
    for (int i = 0; i < len; i++) begin
      e.bits[1 + i] = d[i];
      ones ^= d[i];
    end
    n = 1 + len;
    if (c[3]) begin
      if (c[5]) e.bits[n] = ~c[4];
      else if (c[4]) e.bits[n] = ones;
      else e.bits[n] = ~ones;
      n++;
    end
    st = !c[2] ? 16 : ((len == 5) ? 24 : 32);
    e.total = 16 * n + st;
    e.nsamp = (e.total + 7) / 16;
    for (int i = n; i < e.nsamp; i++) e.bits[i] = 1'b1;
    if (use_brk) e.bits = '0;
    e.tag = tag;
    exp_q.push_back(e);

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    line_ctrl = c;
    brk       = use_brk;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 ready low in frame", 32'(in_ready), 32'd0);
    if (scramble) begin
      line_ctrl = ~c;
      in_data   = ~d;
    end
    if (poke_valid) begin
      repeat (40) @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h00;
      repeat (20) @(negedge clk);
      in_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, {"R1 idle after ", tag}, 32'(txd), 32'd1);
    chk(in_ready == 1'b1, {"R1 ready after ", tag}, 32'(in_ready), 32'd1);
  endtask

  initial begin
    n_checks  = 0;
    n_bad     = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    line_ctrl = '0;
    brk       = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(txd == 1'b1, "R1 reset txd", 32'(txd), 32'd1);
    chk(busy == 1'b0, "R1 reset busy", 32'(busy), 32'd0);
    chk(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);

    send(8'hA5, 8'h03, 1'b0, 1'b0, 1'b0, "R3 8-bit");
    send(8'hE6, 8'h00, 1'b0, 1'b0, 1'b0, "R3 R11 5-bit");
    send(8'h2D, 8'h01, 1'b0, 1'b0, 1'b0, "R4 6-bit no parity");
    send(8'h53, 8'h1A, 1'b0, 1'b0, 1'b0, "R5 even 7-bit");
    send(8'h2D, 8'h09, 1'b0, 1'b0, 1'b0, "R5 odd 6-bit");
    send(8'hFF, 8'h3B, 1'b0, 1'b0, 1'b0, "R6 fixed zero");
    send(8'h00, 8'h2B, 1'b0, 1'b0, 1'b0, "R6 fixed one");
    send(8'h15, 8'h04, 1'b0, 1'b0, 1'b0, "R7 one and half");
    send(8'h3C, 8'h07, 1'b0, 1'b0, 1'b0, "R7 two stop 8-bit");
    send(8'h1B, 8'h05, 1'b0, 1'b0, 1'b0, "R7 two stop 6-bit");
    send(8'hE0, 8'h18, 1'b0, 1'b0, 1'b0, "R11 masked parity");
    send(8'h81, 8'h1B, 1'b0, 1'b1, 1'b0, "R10 ctrl change");
    send(8'h5A, 8'h0F, 1'b1, 1'b0, 1'b0, "R9 break");
    send(8'h77, 8'h03, 1'b0, 1'b0, 1'b1, "R2 valid ignored");

    repeat (300) @(negedge clk);
    chk(busy == 1'b0, "R2 no extra frame", 32'(busy), 32'd0);
    chk(exp_q.size() == 0, "R8 frames left", 32'(exp_q.size()), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule